// File: doc/BRIEF.md
# Extended-Precision Floating Remainder Unit

The unit takes two 80-bit extended-precision operands, a dividend and a divisor. Each operand has a sign in bit 79, a 15-bit biased exponent in bits 78:64 and a 64-bit significand in bits 63:0 with an explicit integer bit at bit 63. The unit returns the truncating remainder: the dividend minus the divisor times the quotient, where the quotient is rounded toward zero. It is not the IEEE round-to-nearest remainder. The result is exact, carries the dividend's sign, and is packed as a normalized number, or as a subnormal when the exponent would drop below 1.

A request is accepted with a one-cycle `start` while the unit is idle. The operands are captured at that edge. The controller then decodes NaNs, infinities, zeros and subnormal inputs. Operands that need real work go through a restoring shift-subtract loop, one step per cycle, on a 65-bit partial remainder. The loop runs exponent-difference plus one times. The remainder is then normalized and packed. A one-cycle `done` marks a valid `result` and `invalid`, and both hold their values until the next accepted request.

The controller has five states, with these transitions:
- ST_IDLE goes to ST_DECODE on `start`.
- ST_DECODE goes to ST_DONE for a special case, and to ST_REDUCE otherwise.
- ST_REDUCE loops on itself until its step counter reaches zero, then goes to ST_PACK.
- ST_PACK goes to ST_DONE.
- ST_DONE goes to ST_IDLE.

Top module: `fprem_unit`

## Requirements
- R1: If either operand is a NaN (exponent 0x7FFF, bits 62:0 nonzero), the result is that NaN with bit 62 set to 1. The dividend wins when both are NaNs.
- R2: `invalid` is 1 when a NaN operand is signaling (bit 62 = 0). It stays 0 when the NaN operands are all quiet.
- R3: An infinite dividend (exponent 0x7FFF, bits 62:0 zero) with a non-NaN divisor sets `invalid` and returns the default NaN 0x7FFF_C000000000000000.
- R4: An infinite divisor with a finite dividend returns the dividend bit for bit, with `invalid` at 0.
- R5: A zero divisor (exponent 0, significand 0) sets `invalid` and returns the default NaN, even when the dividend is zero.
- R6: A zero dividend with a nonzero, non-NaN, finite divisor returns the dividend unchanged, sign included.
- R7: If the dividend's exponent is below the divisor's (after subnormals are normalized), the dividend is returned unchanged.
- R8: For finite nonzero operands, the result is the exact truncating remainder with the dividend's sign. Its magnitude is below the divisor's, and it is normalized so that bit 63 is 1.
- R9: A remainder that is exactly zero returns a zero (exponent 0, significand 0) carrying the dividend's sign.
- R10: Subnormal operands are normalized before use. A remainder whose exponent would fall below 1 is returned as a subnormal with exponent field 0.
- R11: `busy` rises on the edge after `start` is accepted and stays high through the `done` cycle. `done` lasts one cycle. `start` while busy is ignored. `result` and `invalid` hold their values while idle.
- R12: `done` appears 1 edge after the start edge for every case decided at decode (R1 to R7), and d+3 edges after it otherwise, where d is the exponent difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a request when idle |
| op_a | input | 80 | Dividend |
| op_b | input | 80 | Divisor |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 80 | Remainder or NaN |
| invalid | output | 1 | Invalid-operation flag for the last request |

## Verification
A wrong step counter or exponent-difference load shows up on the first ordinary request in two ways: `done` arrives on the wrong edge, and the remainder is off by a multiple of the divisor. The bench therefore checks the latency of every request as well as its value. A controller that mis-routes a special case shows up as a wrong NaN, a wrong dividend echo or a wrong `invalid` value at the very next `done`. A remainder register corrupted in the last step or in the pack stage shows up as a wrong exponent or a lost integer bit in that same result. The sweep over exponent differences from 0 to 70, plus long and subnormal cases, exposes each of these faults within one request.

// File: rtl/fprem_pkg.sv
package fprem_pkg;
    localparam int EXP_W  = 15;
    localparam int SIG_W  = 64;
    localparam int FP_W   = 1 + EXP_W + SIG_W;
    localparam int XEXP_W = EXP_W + 2;
    localparam int LZ_W   = $clog2(SIG_W) + 1;

    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
    localparam logic [FP_W-1:0]  DEFAULT_NAN =
        {1'b0, EXP_ALL1, 2'b11, {(SIG_W-2){1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_REDUCE,
        ST_PACK,
        ST_DONE
    } fsm_state_t;

    typedef struct packed {
        logic              is_nan;
        logic              is_snan;
        logic              is_inf;
        logic              is_zero;
        logic [XEXP_W-1:0] eff_exp;
        logic [SIG_W-1:0]  sig;
    } op_info_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [SIG_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            found;
        n     = LZ_W'(SIG_W);
        found = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!found && v[i]) begin
                n     = LZ_W'(SIG_W - 1 - i);
                found = 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fprem_classify.sv
module fprem_classify
    import fprem_pkg::*;
#(
    parameter bit FORCE_INT = 1'b0
) (
    input  logic [FP_W-1:0] op_i,
    output op_info_t        info_o
);
    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig_f;
    logic             frac_nz;
    logic [LZ_W-1:0]  lz;

    always_comb begin
        exp_f   = op_i[FP_W-2:SIG_W];
        sig_f   = op_i[SIG_W-1:0];
        frac_nz = |sig_f[SIG_W-2:0];
        lz      = lead_zeros(sig_f);

        info_o.is_nan  = (exp_f == EXP_ALL1) && frac_nz;
        info_o.is_snan = (exp_f == EXP_ALL1) && frac_nz && !sig_f[SIG_W-2];
        info_o.is_inf  = (exp_f == EXP_ALL1) && !frac_nz;
        info_o.is_zero = (exp_f == '0) && (sig_f == '0);

        if (exp_f == '0) begin
            info_o.sig     = (sig_f == '0) ? '0 : (sig_f << lz);
            info_o.eff_exp = XEXP_W'(1) - XEXP_W'(lz);
        end else begin
            info_o.sig     = FORCE_INT ? (sig_f | {1'b1, {(SIG_W-1){1'b0}}}) : sig_f;
            info_o.eff_exp = XEXP_W'(exp_f);
        end
    end
endmodule

// File: rtl/fprem_step.sv
module fprem_step #(
    parameter int W = 64
) (
    input  logic [W:0]   rem_i,
    input  logic [W-1:0] div_i,
    input  logic         last_i,
    output logic [W:0]   rem_o
);
    logic [W:0] div_x;
    logic [W:0] diff;
    logic [W:0] kept;

    always_comb begin
        div_x = {1'b0, div_i};
        diff  = rem_i - div_x;
        kept  = (rem_i >= div_x) ? diff : rem_i;
        rem_o = last_i ? kept : {kept[W-1:0], 1'b0};
    end
endmodule

// File: rtl/fprem_pack.sv
module fprem_pack
    import fprem_pkg::*;
(
    input  logic [SIG_W-1:0]  rem_i,
    input  logic [XEXP_W-1:0] base_i,
    input  logic              sign_i,
    output logic [FP_W-1:0]   val_o
);
    localparam int SH_W = LZ_W - 1;

    logic [LZ_W-1:0]          lz;
    logic signed [XEXP_W-1:0] base_s;
    logic signed [XEXP_W-1:0] exp_s;
    logic [XEXP_W-1:0]        sh_full;
    logic [SH_W-1:0]          sh;

    always_comb begin
        lz      = lead_zeros(rem_i);
        base_s  = $signed(base_i);
        exp_s   = base_s - $signed(XEXP_W'(lz));
        sh_full = '0;
        sh      = '0;
        if (rem_i == '0) begin
            val_o = {sign_i, {(FP_W-1){1'b0}}};
        end else if (exp_s >= $signed(XEXP_W'(1))) begin
            val_o = {sign_i, exp_s[EXP_W-1:0], rem_i << lz};
        end else if (base_s >= $signed(XEXP_W'(1))) begin
            sh_full = XEXP_W'(base_s - $signed(XEXP_W'(1)));
            sh      = sh_full[SH_W-1:0];
            val_o   = {sign_i, {EXP_W{1'b0}}, rem_i << sh};
        end else begin
            sh_full = XEXP_W'($signed(XEXP_W'(1)) - base_s);
            sh      = sh_full[SH_W-1:0];
            val_o   = {sign_i, {EXP_W{1'b0}}, rem_i >> sh};
        end
    end
endmodule

// File: rtl/fprem_unit.sv
module fprem_unit
    import fprem_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic            busy,
    output logic            done,
    output logic [FP_W-1:0] result,
    output logic            invalid
);
    localparam logic [FP_W-1:0] QUIET_BIT = FP_W'(1) << (SIG_W - 2);

    fsm_state_t state_q, state_d;

    logic [FP_W-1:0]   a_q, b_q;
    logic [SIG_W:0]    rem_q;
    logic [SIG_W:0]    rem_nxt;
    logic [SIG_W-1:0]  dsig_q;
    logic [XEXP_W-1:0] cnt_q;
    logic [XEXP_W-1:0] base_q;
    logic              sign_q;
    logic [FP_W-1:0]   res_q;
    logic              inv_q;

    op_info_t cls_a, cls_b;

    logic signed [XEXP_W-1:0] exp_diff;
    logic                     spec_hit;
    logic [FP_W-1:0]          spec_val;
    logic                     spec_inv;
    logic [FP_W-1:0]          pack_val;
    logic                     last_step;

    fprem_classify #(.FORCE_INT(1'b0)) u_cls_a (.op_i(a_q), .info_o(cls_a));
    fprem_classify #(.FORCE_INT(1'b1)) u_cls_b (.op_i(b_q), .info_o(cls_b));

    assign last_step = (cnt_q == '0);

    fprem_step #(.W(SIG_W)) u_step (
        .rem_i  (rem_q),
        .div_i  (dsig_q),
        .last_i (last_step),
        .rem_o  (rem_nxt)
    );

    fprem_pack u_pack (
        .rem_i  (rem_q[SIG_W-1:0]),
        .base_i (base_q),
        .sign_i (sign_q),
        .val_o  (pack_val)
    );

    // special-case decode, priority ordered
    always_comb begin
        exp_diff = $signed(cls_a.eff_exp) - $signed(cls_b.eff_exp);
        spec_hit = 1'b1;
        spec_inv = 1'b0;
        spec_val = a_q;
        if (cls_a.is_nan || cls_b.is_nan) begin
            spec_val = cls_a.is_nan ? (a_q | QUIET_BIT) : (b_q | QUIET_BIT);
            spec_inv = cls_a.is_snan || cls_b.is_snan;
        end else if (cls_a.is_inf) begin
            spec_val = DEFAULT_NAN;
            spec_inv = 1'b1;
        end else if (cls_b.is_inf) begin
            spec_val = a_q;
        end else if (cls_b.is_zero) begin
            spec_val = DEFAULT_NAN;
            spec_inv = 1'b1;
        end else if (cls_a.is_zero) begin
            spec_val = a_q;
        end else if (exp_diff < 0) begin
            spec_val = a_q;
        end else begin
            spec_hit = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DECODE;
            ST_DECODE: state_d = spec_hit ? ST_DONE : ST_REDUCE;
            ST_REDUCE: if (last_step) state_d = ST_PACK;
            ST_PACK:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        result  = res_q;
        invalid = inv_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            rem_q  <= '0;
            dsig_q <= '0;
            cnt_q  <= '0;
            base_q <= '0;
            sign_q <= 1'b0;
            res_q  <= '0;
            inv_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q <= op_a;
                        b_q <= op_b;
                    end
                end
                ST_DECODE: begin
                    if (spec_hit) begin
                        res_q <= spec_val;
                        inv_q <= spec_inv;
                    end else begin
                        rem_q  <= {1'b0, cls_a.sig};
                        dsig_q <= cls_b.sig;
                        cnt_q  <= XEXP_W'(exp_diff);
                        base_q <= cls_b.eff_exp;
                        sign_q <= a_q[FP_W-1];
                    end
                end
                ST_REDUCE: begin
                    rem_q <= rem_nxt;
                    if (!last_step) cnt_q <= cnt_q - XEXP_W'(1);
                end
                ST_PACK: begin
                    res_q <= pack_val;
                    inv_q <= 1'b0;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fprem_unit_chk.sv
module fprem_unit_chk
    import fprem_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            a_sign,
    input logic            busy,
    input logic            done,
    input logic [FP_W-1:0] result,
    input logic            invalid
);
    logic sign_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             sign_cap <= 1'b0;
        else if (start && !busy) sign_cap <= a_sign;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(result) && $stable(invalid)));

    // R3
    invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> ((result[FP_W-2:SIG_W] == EXP_ALL1) && result[SIG_W-2]));

    // R8
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[FP_W-2:SIG_W] != EXP_ALL1)) |-> (result[FP_W-1] == sign_cap));
endmodule

bind fprem_unit fprem_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a_sign  (op_a[fprem_pkg::FP_W-1]),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .invalid (invalid)
);

// File: tb/tb_fprem_unit.sv
`timescale 1ns/1ps
module tb_fprem_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] op_a = '0;
    logic [79:0] op_b = '0;
    logic        busy, done, invalid;
    logic [79:0] result;

    int checks = 0;
    int errors = 0;

    localparam logic [79:0] DEF_NAN = 80'h7FFF_C000_0000_0000_0000;

    always #2.5 clk = ~clk;

    fprem_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result), .invalid(invalid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [79:0] a, input logic [79:0] b,
                         output logic [79:0] r, output logic inv,
                         output string tag, output int lat);
        logic an, asn, bn, bsn, ainf, binf, az, bz;
        int ae, be, d, e;
        logic [63:0] asg, bsg, s;
        logic [127:0] x;
        an   = (a[78:64] == 15'h7FFF) && (a[62:0] != 0);
        bn   = (b[78:64] == 15'h7FFF) && (b[62:0] != 0);
        asn  = an && !a[62];
        bsn  = bn && !b[62];
        ainf = (a[78:64] == 15'h7FFF) && (a[62:0] == 0);
        binf = (b[78:64] == 15'h7FFF) && (b[62:0] == 0);
        az   = (a[78:0] == 0);
        bz   = (b[78:0] == 0);
        inv = 1'b0; lat = 1; tag = "R1"; r = a;
        if (an || bn) begin
            r   = an ? (a | (80'd1 << 62)) : (b | (80'd1 << 62));
            inv = asn || bsn;
            tag = inv ? "R2" : "R1";
        end else if (ainf) begin
            r = DEF_NAN; inv = 1'b1; tag = "R3";
        end else if (binf) begin
            r = a; tag = "R4";
        end else if (bz) begin
            r = DEF_NAN; inv = 1'b1; tag = "R5";
        end else if (az) begin
            r = a; tag = "R6";
        end else begin
            asg = a[63:0]; ae = int'(a[78:64]);
            if (ae == 0) begin ae = 1; while (!asg[63]) begin asg = asg << 1; ae--; end end
            bsg = b[63:0]; be = int'(b[78:64]);
            if (be == 0) begin be = 1; while (!bsg[63]) begin bsg = bsg << 1; be--; end end
            else bsg[63] = 1'b1;
            d = ae - be;
            if (d < 0) begin
                r = a; tag = "R7";
            end else begin
                lat = d + 3;
                x = {64'd0, asg} % {64'd0, bsg};
                for (int i = 0; i < d; i++) x = (x << 1) % {64'd0, bsg};
                s = x[63:0]; e = be;
                if (s == 0) begin
                    r = {a[79], 79'd0}; tag = "R9";
                end else begin
                    while (!s[63] && e > 1) begin s = s << 1; e--; end
                    if (e < 1) begin s = s >> (1 - e); e = 0; end
                    else if (!s[63]) e = 0;
                    r = {a[79], 15'(e), s};
                    tag = (a[78:64] == 0 || b[78:64] == 0 || e == 0) ? "R10" : "R8";
                end
            end
        end
    endtask

    task automatic run_op(input logic [79:0] a, input logic [79:0] b,
                          output logic [79:0] r, output logic inv, output int n);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40000) begin
            @(posedge clk); n++; @(negedge clk);
        end
        r = result; inv = invalid;
    endtask

    task automatic verify(input logic [79:0] a, input logic [79:0] b);
        logic [79:0] er, ar;
        logic ei, ai;
        string tag;
        int el, al;
        model(a, b, er, ei, tag, el);
        run_op(a, b, ar, ai, al);
        check(ar === er, tag, "result", ar, er);
        check(ai === ei, tag, "invalid", {79'd0, ai}, {79'd0, ei});
        check(al == el, "R12", "latency", 80'(al), 80'(el));
        @(negedge clk);
        check(done === 1'b0, "R11", "done pulse", {79'd0, done}, 80'd0);
    endtask

    function automatic logic [79:0] kind(input int k);
        case (k)
            0: return 80'h0000_0000_0000_0000_0000;
            1: return 80'h8000_0000_0000_0000_0000;
            2: return 80'h7FFF_C000_0000_0000_0001;
            3: return 80'hFFFF_8000_0000_0000_0005;
            4: return 80'h7FFF_8000_0000_0000_0000;
            5: return 80'hFFFF_8000_0000_0000_0000;
            6: return 80'h3FFF_C000_0000_0000_0000;
            7: return 80'h0000_0000_0000_1234_5678;
            default: return 80'hC005_A5A5_A5A5_A5A5_A5A5;
        endcase
    endfunction

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [79:0] r1, r2, er;
        logic i1, ei;
        int n1, el;
        string tag;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy === 1'b0 && done === 1'b0, "R11", "reset busy/done",
              {78'd0, busy, done}, 80'd0);
        check(result === 80'd0 && invalid === 1'b0, "R11", "reset result",
              result, 80'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1..R7 special-case grid
        for (int i = 0; i < 9; i++)
            for (int j = 0; j < 9; j++)
                verify(kind(i), kind(j));

        // R8 exponent-difference sweep
        for (int d = 0; d <= 70; d++) begin
            for (int k = 0; k < 4; k++) begin
                logic [63:0] pa, pb;
                pa = (64'h9E37_79B9_7F4A_7C15 * 64'(d * 4 + k + 1)) | 64'h8000_0000_0000_0000;
                pb = (64'hD1B5_4A32_D192_ED03 * 64'(k + 3)) | 64'h8000_0000_0000_0000;
                verify({k[0], 15'(16383 + d), pa}, {k[1], 15'h3FFF, pb});
            end
        end

        // R9 exact multiples give signed zero
        verify(80'h4000_C000_0000_0000_0000, 80'h3FFF_C000_0000_0000_0000);
        verify(80'hC003_C000_0000_0000_0000, 80'h3FFF_C000_0000_0000_0000);
        // R10 subnormal operands and subnormal results
        verify(80'h0003_FFFF_FFFF_FFFF_FFFF, 80'h0002_8000_0000_0000_0001);
        verify(80'h0000_0000_0000_00FF_0000, 80'h0000_0000_0000_0000_0301);
        verify(80'h4010_ABCD_EF01_2345_6789, 80'h0000_0000_0000_0000_0007);
        // R8 long reduction
        verify(80'h41F3_F0F0_F0F0_F0F0_F0F1, 80'h3FFF_9999_9999_9999_999B);

        // R11 start while busy is ignored
        model(80'h403B_B7E1_5162_8AED_2A6B, 80'h3FFF_ADF8_5458_A2BB_4A9B, er, ei, tag, el);
        @(negedge clk);
        op_a = 80'h403B_B7E1_5162_8AED_2A6B; op_b = 80'h3FFF_ADF8_5458_A2BB_4A9B; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        op_a = 80'h7FFF_8000_0000_0000_0000; op_b = 80'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n1 = 0;
        while (!done && n1 < 40000) begin @(negedge clk); n1++; end
        r1 = result; i1 = invalid;
        check(r1 === er && i1 === ei, "R11", "start while busy", r1, er);
        // R11 hold while idle
        repeat (6) @(negedge clk);
        r2 = result;
        check(r2 === r1 && busy === 1'b0 && done === 1'b0, "R11", "hold idle", r2, r1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule